// File: doc/BRIEF.md
# Paged Branch and Subroutine Sequencer

This block forms the program fetch address of a small 4-bit microcontroller. A 6-bit program counter selects a word inside a page, a 4-bit page address selects one of 16 pages, and a 2-bit chapter address selects one of four chapters. Together they form a 12-bit ROM address. Jump targets are not taken straight from the instruction. The page and chapter of a target are first placed in a page buffer and a chapter buffer, and a later branch or call moves them into the live address.

An external decoder supplies one strobe per operation, the immediate field of the opcode and the status flag. Branch and call are conditional on status. One level of subroutine nesting is provided through a return register, a chapter save register and a call latch. A call made while the latch is set behaves like a branch. It does not overwrite the saved return point.

Top module: `paged_seq`

## Requirements
- R1: `rom_addr` is {chapter[1:0], page[3:0], pc[5:0]}, chapter in bits 11:10, page in bits 9:6, pc in bits 5:0.
- R2: In a cycle with no taken branch, no taken call and no return, pc becomes (pc+1) mod 64 on the clock edge, and page and chapter hold.
- R3: A branch or call strobe with status 0 is treated as no operation: page, chapter, both buffers and the latch are unchanged, and pc advances as in R2.
- R4: A taken branch (branch strobe, status 1) loads chapter from the chapter buffer and pc from `op_imm`. It loads page from the page buffer only when the call latch is clear; otherwise page holds.
- R5: A taken call with the call latch clear sets the latch, saves (pc+1) mod 64 as the return point, saves the current chapter, and loads page from the page buffer.
- R6: Any taken call loads chapter from the chapter buffer and pc from `op_imm`, and writes the pre-call page into the page buffer. A call with the latch set leaves page, the return point, the saved chapter and the latch as they were.
- R7: A return with the call latch set restores pc from the return point and chapter from the saved chapter, and clears the latch.
- R8: Every return loads page from the page buffer. A return with the latch clear advances pc as in R2 and keeps chapter.
- R9: The transfer strobe loads the chapter buffer with bits 1:0 of the page buffer.
- R10: The load strobe writes `op_imm[3:0]` into the page buffer and leaves page unchanged.
- R11: All registers update on one edge from values held before that edge. A buffer operation in the same cycle as a branch, call or return does not affect the target of that cycle. When a taken call and the load strobe coincide, the call's write to the page buffer wins.
- R12: A synchronous active-high reset clears pc, page, chapter, both buffers, the return point, the saved chapter and the call latch, so `rom_addr` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one instruction cycle per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| status | input | 1 | Condition flag for branch and call |
| br_stb | input | 1 | Branch strobe |
| call_stb | input | 1 | Call strobe |
| ret_stb | input | 1 | Return strobe |
| ldpg_stb | input | 1 | Load page buffer from immediate |
| pg2ch_stb | input | 1 | Transfer page buffer low bits to chapter buffer |
| op_imm | input | 6 | Opcode immediate field |
| rom_addr | output | 12 | ROM fetch address |

## Verification
A buffer operation can fall in the same cycle as a flow operation. The load or transfer strobe can come with a branch, a call or a return, and the load strobe can also come with a call that writes the same page buffer. The random stimulus raises the two buffer strobes independently of the exclusive flow strobes and the status flag, so these overlaps occur often. Directed steps place a load on a taken branch and a load on a nested call. The result is judged by a bench model that updates every register from pre-edge values. A later branch then exposes the buffer contents through `rom_addr`, which shows whether the branch used the old buffer value and whether the call's page write won.

// File: rtl/pseq_pkg.sv
package pseq_pkg;

    localparam int PC_W   = 6;
    localparam int PAGE_W = 4;
    localparam int CHAP_W = 2;
    localparam int ADDR_W = CHAP_W + PAGE_W + PC_W;

    typedef struct packed {
        logic [CHAP_W-1:0] chap;
        logic [PAGE_W-1:0] page;
        logic [PC_W-1:0]   pc;
    } rom_addr_t;

    // Resolved control flow for one instruction cycle
    typedef enum logic [2:0] {
        FLOW_SEQ      = 3'd0,   // plain advance
        FLOW_BR_TOP   = 3'd1,   // taken branch, latch clear
        FLOW_BR_SUB   = 3'd2,   // taken branch, latch set
        FLOW_CALL_TOP = 3'd3,   // taken call, latch clear
        FLOW_CALL_SUB = 3'd4,   // taken call, latch set
        FLOW_RET_SUB  = 3'd5,   // return, latch set
        FLOW_RET_TOP  = 3'd6    // return, latch clear
    } flow_e;

    function automatic logic [PC_W-1:0] pc_inc(input logic [PC_W-1:0] v);
        return v + PC_W'(1);
    endfunction

    function automatic logic is_call(input flow_e f);
        return (f == FLOW_CALL_TOP) || (f == FLOW_CALL_SUB);
    endfunction

    function automatic logic is_jump(input flow_e f);
        return (f == FLOW_BR_TOP) || (f == FLOW_BR_SUB) || is_call(f);
    endfunction

    function automatic logic is_ret(input flow_e f);
        return (f == FLOW_RET_SUB) || (f == FLOW_RET_TOP);
    endfunction

endpackage

// File: rtl/pseq_flow_decode.sv
module pseq_flow_decode
    import pseq_pkg::*;
(
    input  logic  status,
    input  logic  br_stb,
    input  logic  call_stb,
    input  logic  ret_stb,
    input  logic  in_sub,
    output flow_e flow
);
    always_comb begin
        flow = FLOW_SEQ;
        if (br_stb && status) begin
            flow = in_sub ? FLOW_BR_SUB : FLOW_BR_TOP;
        end else if (call_stb && status) begin
            flow = in_sub ? FLOW_CALL_SUB : FLOW_CALL_TOP;
        end else if (ret_stb) begin
            flow = in_sub ? FLOW_RET_SUB : FLOW_RET_TOP;
        end
    end
endmodule

// File: rtl/pseq_link.sv
module pseq_link
    import pseq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  flow_e flow,
    output logic  in_sub
);
    always_ff @(posedge clk) begin
        if (rst) begin
            in_sub <= 1'b0;
        end else begin
            case (flow)
                FLOW_CALL_TOP: in_sub <= 1'b1;
                FLOW_RET_SUB:  in_sub <= 1'b0;
                default:       in_sub <= in_sub;
            endcase
        end
    end

    assert_call_sets_latch_R5: assert property (@(posedge clk) disable iff (rst)
        flow == FLOW_CALL_TOP |=> in_sub);

    assert_ret_clears_latch_R7: assert property (@(posedge clk) disable iff (rst)
        flow == FLOW_RET_SUB |=> !in_sub);

    assert_nested_call_keeps_latch_R6: assert property (@(posedge clk) disable iff (rst)
        flow == FLOW_CALL_SUB |=> in_sub);
endmodule

// File: rtl/pseq_pc_unit.sv
module pseq_pc_unit
    import pseq_pkg::*;
#(
    parameter int W = pseq_pkg::PC_W
)(
    input  logic         clk,
    input  logic         rst,
    input  flow_e        flow,
    input  logic [W-1:0] imm,
    output logic [W-1:0] pc
);
    logic [W-1:0] ret_pc;
    logic [W-1:0] pc_nxt;

    assign pc_nxt = pc + W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc     <= '0;
            ret_pc <= '0;
        end else begin
            case (flow)
                FLOW_BR_TOP, FLOW_BR_SUB, FLOW_CALL_SUB: pc <= imm;
                FLOW_CALL_TOP: begin
                    pc     <= imm;
                    ret_pc <= pc_nxt;
                end
                FLOW_RET_SUB:  pc <= ret_pc;
                default:       pc <= pc_nxt;
            endcase
        end
    end

    assert_pc_advance_R2: assert property (@(posedge clk) disable iff (rst)
        (flow == FLOW_SEQ || flow == FLOW_RET_TOP) |=> pc == W'($past(pc) + W'(1)));

    assert_jump_target_R4: assert property (@(posedge clk) disable iff (rst)
        is_jump(flow) |=> pc == $past(imm));

    assert_ret_point_saved_R5: assert property (@(posedge clk) disable iff (rst)
        flow == FLOW_CALL_TOP |=> ret_pc == W'($past(pc) + W'(1)));

    assert_nested_keeps_ret_R6: assert property (@(posedge clk) disable iff (rst)
        flow == FLOW_CALL_SUB |=> $stable(ret_pc));
endmodule

// File: rtl/pseq_bank_unit.sv
module pseq_bank_unit
    import pseq_pkg::*;
#(
    parameter int PW = pseq_pkg::PAGE_W,
    parameter int CW = pseq_pkg::CHAP_W
)(
    input  logic          clk,
    input  logic          rst,
    input  flow_e         flow,
    input  logic          ldpg_stb,
    input  logic          pg2ch_stb,
    input  logic [PW-1:0] pg_imm,
    output logic [PW-1:0] page,
    output logic [CW-1:0] chap
);
    logic [PW-1:0] pbuf;
    logic [CW-1:0] cbuf;
    logic [CW-1:0] chap_save;

    // Live page and chapter
    always_ff @(posedge clk) begin
        if (rst) begin
            page      <= '0;
            chap      <= '0;
            chap_save <= '0;
        end else begin
            case (flow)
                FLOW_BR_TOP: begin
                    page <= pbuf;
                    chap <= cbuf;
                end
                FLOW_BR_SUB, FLOW_CALL_SUB: chap <= cbuf;
                FLOW_CALL_TOP: begin
                    page      <= pbuf;
                    chap      <= cbuf;
                    chap_save <= chap;
                end
                FLOW_RET_SUB: begin
                    page <= pbuf;
                    chap <= chap_save;
                end
                FLOW_RET_TOP: page <= pbuf;
                default: ;
            endcase
        end
    end

    // Buffers: a taken call owns the page buffer in its cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            pbuf <= '0;
            cbuf <= '0;
        end else begin
            if (is_call(flow)) begin
                pbuf <= page;
            end else if (ldpg_stb) begin
                pbuf <= pg_imm;
            end
            if (pg2ch_stb) begin
                cbuf <= pbuf[CW-1:0];
            end
        end
    end

    assert_seq_holds_bank_R2: assert property (@(posedge clk) disable iff (rst)
        flow == FLOW_SEQ |=> ($stable(page) && $stable(chap)));

    assert_sub_branch_keeps_page_R4: assert property (@(posedge clk) disable iff (rst)
        flow == FLOW_BR_SUB |=> $stable(page));

    assert_call_swaps_page_R6: assert property (@(posedge clk) disable iff (rst)
        is_call(flow) |=> pbuf == $past(page));

    assert_ret_loads_page_R8: assert property (@(posedge clk) disable iff (rst)
        is_ret(flow) |=> page == $past(pbuf));

    assert_xfer_chapter_R9: assert property (@(posedge clk) disable iff (rst)
        pg2ch_stb |=> cbuf == $past(pbuf[CW-1:0]));

    assert_load_pbuf_R10: assert property (@(posedge clk) disable iff (rst)
        (ldpg_stb && !is_call(flow)) |=> pbuf == $past(pg_imm));
endmodule

// File: rtl/paged_seq.sv
module paged_seq
    import pseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              status,
    input  logic              br_stb,
    input  logic              call_stb,
    input  logic              ret_stb,
    input  logic              ldpg_stb,
    input  logic              pg2ch_stb,
    input  logic [PC_W-1:0]   op_imm,
    output logic [ADDR_W-1:0] rom_addr
);
    flow_e             flow;
    logic              in_sub;
    logic [PC_W-1:0]   pc;
    logic [PAGE_W-1:0] page;
    logic [CHAP_W-1:0] chap;
    rom_addr_t         addr_s;

    pseq_flow_decode u_dec (
        .status   (status),
        .br_stb   (br_stb),
        .call_stb (call_stb),
        .ret_stb  (ret_stb),
        .in_sub   (in_sub),
        .flow     (flow)
    );

    pseq_link u_link (
        .clk    (clk),
        .rst    (rst),
        .flow   (flow),
        .in_sub (in_sub)
    );

    pseq_pc_unit #(.W(PC_W)) u_pc (
        .clk  (clk),
        .rst  (rst),
        .flow (flow),
        .imm  (op_imm),
        .pc   (pc)
    );

    pseq_bank_unit #(.PW(PAGE_W), .CW(CHAP_W)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .flow      (flow),
        .ldpg_stb  (ldpg_stb),
        .pg2ch_stb (pg2ch_stb),
        .pg_imm    (op_imm[PAGE_W-1:0]),
        .page      (page),
        .chap      (chap)
    );

    always_comb begin
        addr_s.chap = chap;
        addr_s.page = page;
        addr_s.pc   = pc;
    end
    assign rom_addr = addr_s;

    assert_reset_clears_R12: assert property (@(posedge clk)
        rst |=> rom_addr == '0);

    assert_untaken_holds_R3: assert property (@(posedge clk) disable iff (rst)
        ((br_stb || call_stb) && !status && !ret_stb)
            |=> ($stable(rom_addr[ADDR_W-1:PC_W]) && $stable(in_sub)));
endmodule

// File: tb/paged_seq_tb.sv
module paged_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 4000;
    localparam int WATCHDOG   = 50000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       status = 1'b0;
    logic       br_stb = 1'b0, call_stb = 1'b0, ret_stb = 1'b0;
    logic       ldpg_stb = 1'b0, pg2ch_stb = 1'b0;
    logic [5:0] op_imm = '0;
    logic [11:0] rom_addr;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // Bench model state
    logic [5:0] e_pc, e_rpc;
    logic [3:0] e_page, e_pbuf;
    logic [1:0] e_chap, e_cbuf, e_csave;
    logic       e_lat;

    always #(CLK_PERIOD/2) clk = ~clk;

    paged_seq u_dut (
        .clk       (clk),
        .rst       (rst),
        .status    (status),
        .br_stb    (br_stb),
        .call_stb  (call_stb),
        .ret_stb   (ret_stb),
        .ldpg_stb  (ldpg_stb),
        .pg2ch_stb (pg2ch_stb),
        .op_imm    (op_imm),
        .rom_addr  (rom_addr)
    );

    function automatic logic [11:0] exp_addr();
        return {e_chap, e_page, e_pc};
    endfunction

    function automatic string pick_tag(input bit r, input bit b, input bit c,
                                       input bit t, input bit l, input bit x,
                                       input bit s, input bit lat);
        if (r)                 return "R12";
        if (c && s && l)       return "R11";
        if (b && s)            return "R4";
        if (c && s)            return lat ? "R6" : "R5";
        if (t)                 return lat ? "R7" : "R8";
        if ((b || c) && !s)    return "R3";
        if (x)                 return "R9";
        if (l)                 return "R10";
        return "R2";
    endfunction

    task automatic model_reset();
        e_pc = '0; e_rpc = '0; e_page = '0; e_pbuf = '0;
        e_chap = '0; e_cbuf = '0; e_csave = '0; e_lat = 1'b0;
    endtask

    task automatic model_step(input bit b, input bit c, input bit t,
                              input bit l, input bit x, input bit s,
                              input logic [5:0] imm);
        logic [5:0] o_pc   = e_pc,   o_rpc  = e_rpc;
        logic [3:0] o_page = e_page, o_pbuf = e_pbuf;
        logic [1:0] o_chap = e_chap, o_cbuf = e_cbuf, o_cs = e_csave;
        logic       o_lat  = e_lat;
        e_pc = o_pc + 6'd1;
        if (b && s) begin
            if (!o_lat) e_page = o_pbuf;
            e_chap = o_cbuf;
            e_pc   = imm;
        end else if (c && s) begin
            if (!o_lat) begin
                e_rpc   = o_pc + 6'd1;
                e_lat   = 1'b1;
                e_page  = o_pbuf;
                e_csave = o_chap;
            end
            e_chap = o_cbuf;
            e_pc   = imm;
        end else if (t) begin
            if (o_lat) begin
                e_pc   = o_rpc;
                e_chap = o_cs;
                e_lat  = 1'b0;
            end
            e_page = o_pbuf;
        end
        if (c && s)  e_pbuf = o_page;
        else if (l)  e_pbuf = imm[3:0];
        if (x)       e_cbuf = o_pbuf[1:0];
    endtask

    task automatic check(input string tag, input logic [11:0] exp);
        n_checks++;
        if (rom_addr !== exp) begin
            n_fail++;
            $display("FAIL %s: rom_addr actual=%03h expected=%03h", tag, rom_addr, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge after the update
    task automatic step(input bit r, input bit b, input bit c, input bit t,
                        input bit l, input bit x, input bit s,
                        input logic [5:0] imm, input string tag);
        rst = r; br_stb = b; call_stb = c; ret_stb = t;
        ldpg_stb = l; pg2ch_stb = x; status = s; op_imm = imm;
        if (r) model_reset();
        else   model_step(b, c, t, l, x, s, imm);
        @(posedge clk);
        @(negedge clk);
        check(tag, exp_addr());
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=expired expected=completion");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd20150117));
        model_reset();
        @(negedge clk);
        // R12 and R1: reset state reads zero in every field
        step(1, 0, 0, 0, 0, 0, 0, 6'd0, "R12");
        step(1, 0, 0, 0, 0, 0, 0, 6'd0, "R1 R12");
        // R10: load page buffer, page unchanged
        step(0, 0, 0, 0, 1, 0, 0, 6'd5, "R10");
        // R9: transfer, chapter buffer = 5 & 3 = 1
        step(0, 0, 0, 0, 0, 1, 0, 6'd0, "R9");
        // R11: load in same cycle as branch; branch uses old buffer (page 5)
        step(0, 1, 0, 0, 1, 0, 1, 6'd9, "R11");
        // R1: expect chapter 1, page 5, pc 9
        check("R1", 12'b01_0101_001001);
        // R3: untaken branch and call
        step(0, 1, 0, 0, 0, 0, 0, 6'd40, "R3");
        step(0, 0, 1, 0, 0, 0, 0, 6'd41, "R3");
        // R4 then R2 wrap 63 -> 0
        step(0, 1, 0, 0, 0, 0, 1, 6'd63, "R4");
        step(0, 0, 0, 0, 0, 0, 0, 6'd0, "R2");
        // R5: first call
        step(0, 0, 1, 0, 0, 0, 1, 6'd10, "R5");
        // R11/R6: nested call with coinciding load; call write wins
        step(0, 0, 1, 0, 1, 0, 1, 6'd20, "R11");
        // R4: branch inside subroutine keeps page
        step(0, 1, 0, 0, 0, 0, 1, 6'd33, "R4");
        // R7: return restores pc and chapter
        step(0, 0, 0, 1, 0, 0, 0, 6'd0, "R7");
        // R8: return with latch clear
        step(0, 0, 0, 1, 0, 0, 0, 6'd0, "R8");
        // Branch to expose the page buffer written by the nested call
        step(0, 1, 0, 0, 0, 0, 1, 6'd2, "R11");

        for (int n = 0; n < N_RANDOM; n++) begin
            int unsigned op = $urandom_range(0, 9);
            bit r = ($urandom_range(0, 199) == 0);
            bit b = (op == 0 || op == 1 || op == 2);
            bit c = (op == 3 || op == 4);
            bit t = (op == 5);
            bit l = ($urandom_range(0, 3) == 0);
            bit x = ($urandom_range(0, 3) == 0);
            bit s = ($urandom_range(0, 3) != 0);
            logic [5:0] imm = 6'($urandom);
            step(r, b, c, t, l, x, s, imm, pick_tag(r, b, c, t, l, x, s, e_lat));
        end

        done = 1;
        finish_run();
    end
endmodule